// File: doc/BRIEF.md
# Protected SMBASE Window Lock Register

This block holds one 8-bit configuration register that firmware uses to find out whether a protected RAM window at the default SMBASE area is available, and then to lock it. The register's write mask changes as the sequence goes on. A magic query write swaps the register's contents for a capability code and narrows the writable bits to a single lock bit. Setting that bit afterwards freezes the register until the next reset.

Alongside the register, the block decides where CPU memory accesses go. Once the window is locked, an access from outside system management mode that falls inside the window is kept away from RAM: reads return all ones and writes are dropped. Accesses made in system management mode, accesses outside the window and every access while unlocked go to RAM unchanged. A build parameter can remove the whole mechanism. In that build the register stays at zero and the window acts as ordinary memory.

Top module: `smbase_guard`

## Requirements
- R1: After reset the register reads 0x00, the locked output is low and all eight bits are writable.
- R2: In the reset state, a write of 0xFF (the query value) makes the register read 0x01 (the RAM-present code) from the next cycle on, and leaves only bit 1 (the lock bit) writable.
- R3: In the reset state, a write of any value other than 0xFF is discarded and the register still reads 0x00.
- R4: After a query, a write with bit 1 clear leaves the register at 0x01 and does not lock.
- R5: After a query, a write with bit 1 set makes the register read exactly 0x02, and the locked output is high from the cycle after that write.
- R6: Once locked, no write changes the register value or the locked output; only reset returns them to 0x00 and low.
- R7: While locked, a valid access inside the window with the SMM flag low does not assert the RAM valid or RAM write outputs, and the returned read data is all ones.
- R8: While locked, a valid access inside the window with the SMM flag high reaches RAM, and its read data comes from RAM.
- R9: While unlocked, or for any address outside the window, a valid access reaches RAM with its write flag passed through and its read data taken from RAM.
- R10: The window covers addresses 0x30000 through 0x4FFFF inclusive (128 KB); 0x2FFFF and 0x50000 lie outside it.
- R11: With the feature parameter off, no write changes the register from 0x00, the locked output stays low and every access reaches RAM.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgWrEn | input | 1 | Configuration write strobe for the register |
| cfgWrData | input | 8 | Configuration write data |
| cfgRdData | output | 8 | Current register value |
| lockedOut | output | 1 | High while the window is locked |
| memValid | input | 1 | CPU memory access valid |
| memWrite | input | 1 | CPU access is a write |
| memAddr | input | 32 | CPU physical address |
| memSmm | input | 1 | CPU access made in system management mode |
| ramRdData | input | 32 | Read data returned by RAM |
| ramValid | output | 1 | Access forwarded to RAM |
| ramWrite | output | 1 | Forwarded access is a write |
| memRdData | output | 32 | Read data returned to the CPU |

## Verification
Every 8-bit write value is applied in each of the three register states: reset, queried and locked. This catches a design that lets a non-query value through in the reset state, that treats 0xFF after a query as a second query instead of a lock (0xFF carries the lock bit), or that lets a locked register be rewritten. The window edges 0x2FFFF, 0x30000, 0x4FFFF and 0x50000 are driven with the SMM flag both low and high, in both lock states. An off-by-one in the range compare would then leak or block a boundary access, and a missing SMM qualifier would block the handler itself. A second instance built with the feature off receives the same writes and must stay at zero and unlocked throughout.

// File: rtl/smbase_guard_pkg.sv
package smbase_guard_pkg;

  // One-hot write actions decided by the control and applied by the datapath.
  typedef struct packed {
    logic takeQuery;  // answer the capability query and narrow the mask
    logic dropWrite;  // reset-state write: discard, register back to zero
    logic takeLock;   // lock bit written: freeze register and mask
    logic takeMerge;  // ordinary masked update
  } ctrlStrobe_t;

endpackage

// File: rtl/smbase_guard_ctrl.sv
module smbase_guard_ctrl
  import smbase_guard_pkg::*;
#(
  parameter int                REG_W      = 8,
  parameter bit                FEATURE_EN = 1'b1,
  parameter logic [REG_W-1:0]  QUERY_CODE = '1,
  parameter logic [REG_W-1:0]  LOCK_MASK  = REG_W'(2)
) (
  input  logic              cfgWrEn,
  input  logic [REG_W-1:0]  mergedVal,
  input  logic              maskFull,
  output ctrlStrobe_t       strobe
);

  generate
    if (FEATURE_EN) begin : g_on
      always_comb begin
        strobe = '0;
        if (cfgWrEn) begin
          // The query test runs on the masked value, so it can only match
          // while every bit is still writable.
          if (mergedVal == QUERY_CODE) begin
            strobe.takeQuery = 1'b1;
          end else if (maskFull) begin
            strobe.dropWrite = 1'b1;
          end else if ((mergedVal & LOCK_MASK) != '0) begin
            strobe.takeLock = 1'b1;
          end else begin
            strobe.takeMerge = 1'b1;
          end
        end
      end
    end else begin : g_off
      logic unusedIn;
      assign unusedIn = cfgWrEn ^ maskFull ^ (^mergedVal);
      assign strobe   = '0;
    end
  endgenerate

endmodule

// File: rtl/smbase_guard_dp.sv
module smbase_guard_dp
  import smbase_guard_pkg::*;
#(
  parameter int                REG_W       = 8,
  parameter logic [REG_W-1:0]  IN_RAM_CODE = REG_W'(1),
  parameter logic [REG_W-1:0]  LOCK_MASK   = REG_W'(2)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [REG_W-1:0]  cfgWrData,
  input  ctrlStrobe_t       strobe,
  output logic [REG_W-1:0]  mergedVal,
  output logic              maskFull,
  output logic [REG_W-1:0]  regVal,
  output logic              lockedQ
);

  logic [REG_W-1:0] valQ;
  logic [REG_W-1:0] maskQ;

  assign mergedVal = (valQ & ~maskQ) | (cfgWrData & maskQ);
  assign maskFull  = &maskQ;
  assign regVal    = valQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      valQ    <= '0;
      maskQ   <= '1;
      lockedQ <= 1'b0;
    end else if (strobe.takeQuery) begin
      valQ  <= IN_RAM_CODE;
      maskQ <= LOCK_MASK;
    end else if (strobe.dropWrite) begin
      valQ <= '0;
    end else if (strobe.takeLock) begin
      valQ    <= LOCK_MASK;
      maskQ   <= maskQ & ~LOCK_MASK;
      lockedQ <= 1'b1;
    end else if (strobe.takeMerge) begin
      valQ <= mergedVal;
    end
  end

endmodule

// File: rtl/smbase_guard_route.sv
module smbase_guard_route #(
  parameter int                 ADDR_W      = 32,
  parameter int                 DATA_W      = 32,
  parameter logic [ADDR_W-1:0]  REGION_BASE = ADDR_W'(32'h0003_0000),
  parameter logic [ADDR_W-1:0]  REGION_SIZE = ADDR_W'(32'h0002_0000)
) (
  input  logic               memValid,
  input  logic               memWrite,
  input  logic [ADDR_W-1:0]  memAddr,
  input  logic               memSmm,
  input  logic [DATA_W-1:0]  ramRdData,
  input  logic               lockedQ,
  output logic               ramValid,
  output logic               ramWrite,
  output logic [DATA_W-1:0]  memRdData
);

  // One extra bit so a window ending at the top of the space does not wrap.
  localparam logic [ADDR_W:0] REGION_END = {1'b0, REGION_BASE} + {1'b0, REGION_SIZE};

  logic inRegion;
  logic blocked;

  assign inRegion  = (memAddr >= REGION_BASE) && ({1'b0, memAddr} < REGION_END);
  assign blocked   = memValid && inRegion && lockedQ && !memSmm;
  assign ramValid  = memValid && !blocked;
  assign ramWrite  = ramValid && memWrite;
  assign memRdData = blocked ? '1 : ramRdData;

endmodule

// File: rtl/smbase_guard.sv
module smbase_guard
  import smbase_guard_pkg::*;
#(
  parameter bit                 FEATURE_EN  = 1'b1,
  parameter int                 ADDR_W      = 32,
  parameter int                 DATA_W      = 32,
  parameter int                 REG_W       = 8,
  parameter logic [ADDR_W-1:0]  REGION_BASE = ADDR_W'(32'h0003_0000),
  parameter logic [ADDR_W-1:0]  REGION_SIZE = ADDR_W'(32'h0002_0000),
  parameter logic [REG_W-1:0]   QUERY_CODE  = '1,
  parameter logic [REG_W-1:0]   IN_RAM_CODE = REG_W'(1),
  parameter logic [REG_W-1:0]   LOCK_MASK   = REG_W'(2)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [REG_W-1:0]   cfgWrData,
  output logic [REG_W-1:0]   cfgRdData,
  output logic               lockedOut,
  input  logic               memValid,
  input  logic               memWrite,
  input  logic [ADDR_W-1:0]  memAddr,
  input  logic               memSmm,
  input  logic [DATA_W-1:0]  ramRdData,
  output logic               ramValid,
  output logic               ramWrite,
  output logic [DATA_W-1:0]  memRdData
);

  ctrlStrobe_t       strobe;
  logic [REG_W-1:0]  mergedVal;
  logic              maskFull;
  logic              lockedQ;

  smbase_guard_ctrl #(
    .REG_W(REG_W), .FEATURE_EN(FEATURE_EN),
    .QUERY_CODE(QUERY_CODE), .LOCK_MASK(LOCK_MASK)
  ) u_ctrl (
    .cfgWrEn(cfgWrEn), .mergedVal(mergedVal), .maskFull(maskFull), .strobe(strobe)
  );

  smbase_guard_dp #(
    .REG_W(REG_W), .IN_RAM_CODE(IN_RAM_CODE), .LOCK_MASK(LOCK_MASK)
  ) u_dp (
    .clk(clk), .rstN(rstN), .cfgWrData(cfgWrData), .strobe(strobe),
    .mergedVal(mergedVal), .maskFull(maskFull), .regVal(cfgRdData), .lockedQ(lockedQ)
  );

  smbase_guard_route #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W),
    .REGION_BASE(REGION_BASE), .REGION_SIZE(REGION_SIZE)
  ) u_route (
    .memValid(memValid), .memWrite(memWrite), .memAddr(memAddr), .memSmm(memSmm),
    .ramRdData(ramRdData), .lockedQ(lockedQ),
    .ramValid(ramValid), .ramWrite(ramWrite), .memRdData(memRdData)
  );

  assign lockedOut = lockedQ;

endmodule

// File: rtl/smbase_guard_chk.sv
module smbase_guard_chk #(
  parameter bit                 FEATURE_EN  = 1'b1,
  parameter int                 ADDR_W      = 32,
  parameter int                 DATA_W      = 32,
  parameter int                 REG_W       = 8,
  parameter logic [ADDR_W-1:0]  REGION_BASE = ADDR_W'(32'h0003_0000),
  parameter logic [ADDR_W-1:0]  REGION_SIZE = ADDR_W'(32'h0002_0000),
  parameter logic [REG_W-1:0]   QUERY_CODE  = '1,
  parameter logic [REG_W-1:0]   IN_RAM_CODE = REG_W'(1),
  parameter logic [REG_W-1:0]   LOCK_MASK   = REG_W'(2)
) (
  input logic               clk,
  input logic               rstN,
  input logic               cfgWrEn,
  input logic [REG_W-1:0]   cfgWrData,
  input logic [REG_W-1:0]   cfgRdData,
  input logic               lockedOut,
  input logic               memValid,
  input logic [ADDR_W-1:0]  memAddr,
  input logic               memSmm,
  input logic [DATA_W-1:0]  ramRdData,
  input logic               ramValid,
  input logic [DATA_W-1:0]  memRdData
);

  localparam logic [ADDR_W:0] LAST_PLUS1 = {1'b0, REGION_BASE} + {1'b0, REGION_SIZE};

  logic winHit;
  assign winHit = (memAddr >= REGION_BASE) && ({1'b0, memAddr} < LAST_PLUS1);

  a_r2_query_answer: assert property (@(posedge clk) disable iff (!rstN)
    FEATURE_EN && cfgWrEn && cfgWrData == QUERY_CODE && cfgRdData == '0
      |=> cfgRdData == IN_RAM_CODE);

  a_r3_reset_discard: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn && cfgWrData != QUERY_CODE && cfgRdData == '0 |=> cfgRdData == '0);

  a_r4_keep_code: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn && (cfgWrData & LOCK_MASK) == '0 && cfgRdData == IN_RAM_CODE
      |=> cfgRdData == IN_RAM_CODE && !lockedOut);

  a_r5_lock_next: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn && (cfgWrData & LOCK_MASK) != '0 && cfgRdData == IN_RAM_CODE
      |=> lockedOut && cfgRdData == LOCK_MASK);

  a_r6_lock_sticky: assert property (@(posedge clk) disable iff (!rstN)
    lockedOut |=> lockedOut && $stable(cfgRdData));

  a_r6_locked_value: assert property (@(posedge clk) disable iff (!rstN)
    lockedOut |-> cfgRdData == LOCK_MASK);

  a_r7_blackhole: assert property (@(posedge clk) disable iff (!rstN)
    memValid && winHit && lockedOut && !memSmm |-> !ramValid && memRdData == '1);

  a_r8_smm_pass: assert property (@(posedge clk) disable iff (!rstN)
    memValid && memSmm |-> ramValid && memRdData == ramRdData);

  a_r9_open_pass: assert property (@(posedge clk) disable iff (!rstN)
    memValid && (!lockedOut || !winHit) |-> ramValid && memRdData == ramRdData);

  a_r11_feature_off: assert property (@(posedge clk) disable iff (!rstN)
    !FEATURE_EN |-> cfgRdData == '0 && !lockedOut);

endmodule

bind smbase_guard smbase_guard_chk #(
  .FEATURE_EN(FEATURE_EN), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_W(REG_W),
  .REGION_BASE(REGION_BASE), .REGION_SIZE(REGION_SIZE),
  .QUERY_CODE(QUERY_CODE), .IN_RAM_CODE(IN_RAM_CODE), .LOCK_MASK(LOCK_MASK)
) u_chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
  .cfgRdData(cfgRdData), .lockedOut(lockedOut), .memValid(memValid),
  .memAddr(memAddr), .memSmm(memSmm), .ramRdData(ramRdData),
  .ramValid(ramValid), .memRdData(memRdData)
);

// File: tb/test_smbase_guard.sv
`timescale 1ns/1ps
module test_smbase_guard;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0;
  logic [7:0]  cfgWrData = '0;
  logic        memValid = 1'b0;
  logic        memWrite = 1'b0;
  logic [31:0] memAddr = '0;
  logic        memSmm = 1'b0;
  logic [31:0] ramRdData = 32'h5A5A_1234;

  logic [7:0]  cfgRdData, offRdData;
  logic        lockedOut, offLocked;
  logic        ramValid, ramWrite, offRamValid, offRamWrite;
  logic [31:0] memRdData, offRdMem;

  int vecCount = 0;
  int errCount = 0;

  always #10 clk = ~clk;

  smbase_guard i_smbase_guard (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(cfgRdData), .lockedOut(lockedOut), .memValid(memValid),
    .memWrite(memWrite), .memAddr(memAddr), .memSmm(memSmm), .ramRdData(ramRdData),
    .ramValid(ramValid), .ramWrite(ramWrite), .memRdData(memRdData)
  );

  smbase_guard #(.FEATURE_EN(1'b0)) i_smbase_guard_off (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .cfgRdData(offRdData), .lockedOut(offLocked), .memValid(memValid),
    .memWrite(memWrite), .memAddr(memAddr), .memSmm(memSmm), .ramRdData(ramRdData),
    .ramValid(offRamValid), .ramWrite(offRamWrite), .memRdData(offRdMem)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    vecCount++;
    if (got !== exp) begin
      errCount++;
      $display("FAIL %s got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
  endtask

  // Drives one write for a full cycle; on return the register has taken it.
  task automatic cfgWrite(input logic [7:0] d);
    @(negedge clk); cfgWrEn = 1'b1; cfgWrData = d;
    @(negedge clk); cfgWrEn = 1'b0;
  endtask

  task automatic checkRoutes(input logic isLocked);
    logic [31:0] addrs [6];
    addrs = '{32'h0002_FFFF, 32'h0003_0000, 32'h0003_ABCD,
              32'h0004_FFFF, 32'h0005_0000, 32'h0000_0000};
    for (int a = 0; a < 6; a++) begin
      for (int s = 0; s < 2; s++) begin
        for (int w = 0; w < 2; w++) begin
          logic inWin, blk;
          @(negedge clk);
          memValid = 1'b1; memAddr = addrs[a]; memSmm = s[0]; memWrite = w[0];
          ramRdData = 32'h5A5A_0000 | a;
          #1;
          inWin = (addrs[a] >= 32'h30000) && (addrs[a] <= 32'h4FFFF);
          blk   = inWin && isLocked && (s == 0);
          // R7 block, R8 smm pass, R9 open pass, R10 window bounds
          check(blk ? "R7 ramValid" : (s == 1 ? "R8 ramValid" : "R9 R10 ramValid"),
                {31'b0, ramValid}, {31'b0, !blk});
          check(blk ? "R7 ramWrite" : "R9 ramWrite", {31'b0, ramWrite},
                {31'b0, !blk && w == 1});
          check(blk ? "R7 rdData" : "R8 R9 rdData", memRdData,
                blk ? 32'hFFFF_FFFF : (32'h5A5A_0000 | a));
          check("R11 off ramValid", {31'b0, offRamValid}, 32'd1);
          check("R11 off rdData", offRdMem, 32'h5A5A_0000 | a);
        end
      end
    end
    @(negedge clk); memValid = 1'b0; memWrite = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errCount++;
    $display("FAIL watchdog expired got running expected finished");
    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset value", {24'b0, cfgRdData}, 32'h00);
    check("R1 reset locked", {31'b0, lockedOut}, 32'd0);
    check("R11 off reset value", {24'b0, offRdData}, 32'h00);

    // Reset-state sweep: only 0xFF is answered (R2), all else discarded (R3).
    for (int d = 0; d < 256; d++) begin
      doReset();
      cfgWrite(8'(d));
      check(d == 255 ? "R2 query answer" : "R3 discard", {24'b0, cfgRdData},
            d == 255 ? 32'h01 : 32'h00);
      check("R3 no lock from reset state", {31'b0, lockedOut}, 32'd0);
      check("R11 off value", {24'b0, offRdData}, 32'h00);
    end

    // Queried-state sweep: bit 1 alone is writable (R4), setting it locks (R5).
    for (int d = 0; d < 256; d++) begin
      doReset();
      cfgWrite(8'hFF);
      cfgWrite(8'(d));
      check(d[1] ? "R5 lock value" : "R4 keep code", {24'b0, cfgRdData},
            d[1] ? 32'h02 : 32'h01);
      check(d[1] ? "R5 locked next cycle" : "R4 stays unlocked", {31'b0, lockedOut},
            {31'b0, d[1]});
      check("R11 off locked", {31'b0, offLocked}, 32'd0);
    end

    // Unlocked routing, then locked routing.
    doReset();
    checkRoutes(1'b0);
    cfgWrite(8'hFF);
    cfgWrite(8'h02);
    checkRoutes(1'b1);

    // Locked-state sweep: nothing moves the register (R6).
    for (int d = 0; d < 256; d++) begin
      cfgWrite(8'(d));
      check("R6 locked value", {24'b0, cfgRdData}, 32'h02);
      check("R6 locked flag", {31'b0, lockedOut}, 32'd1);
    end
    doReset();
    @(negedge clk);
    check("R6 reset clears value", {24'b0, cfgRdData}, 32'h00);
    check("R6 reset clears lock", {31'b0, lockedOut}, 32'd0);
    check("R11 off final", {24'b0, offRdData}, 32'h00);

    $display("  == %0d vectors applied, %0d miscompares ==", vecCount, errCount);
    $finish;
  end

endmodule